// File: doc/BRIEF.md
# Serial BCD Adder-Subtractor

This block is a bit-serial decimal arithmetic unit. Two packed-BCD operands, A and B, arrive on single-bit inputs, one bit per clock and least significant bit first. In add mode the block forms B plus A. In subtract mode it forms B minus A. Four one-hot phase strobes mark the weight of the current bit within its digit, in the order 1, 2, 4, 8. An end-of-number strobe, qualified by the weight-8 phase, marks the last digit of a number.

A first serial adder-subtractor produces the raw binary digit. A four-stage delay line holds that digit. At the weight-8 phase, the raw digit and the binary carry together decide the decimal carry or borrow. That decision becomes the carry into the next digit. It also selects a plus-6 or minus-6 correction for the held digit. A second, reduced serial adder applies the correction as the digit leaves the delay line. The corrected result therefore appears on `sum_bit` one digit period (four clocks) after its operand bits went in. During that same output period, `digit_carry` shows the decimal carry or borrow out of the digit. After the last digit of a number, this flag is the final carry, or the final borrow of a subtraction.

The surrounding datapath keeps `sub` constant for a whole number and keeps exactly one phase strobe active in each clock.

Top module: `bcd_serial_addsub`

## Requirements
- R1: With `sub`=0, every digit leaving on `sum_bit` is the decimal digit of (B + A) mod 10^n at the same position, where n is the number of digits in the number.
- R2: With `sub`=1, every digit leaving on `sum_bit` is the decimal digit of (B - A) mod 10^n. A negative result therefore appears in ten's-complement form.
- R3: The bits of an output digit appear in weight order 1, 2, 4, 8, in the clocks where `ph1`, `ph2`, `ph4` and `ph8` are high. Each output digit is the result for the operand digit fed exactly four clocks earlier.
- R4: Throughout a digit's output period, `digit_carry` is 1 exactly when a decimal carry (add) or borrow (subtract) leaves that digit. A carry is counted when the low i+1 digits of A plus those of B reach 10^(i+1). A borrow is counted when the low i+1 digits of B are less than those of A.
- R5: When `end_num` is high together with `ph8`, the carry or borrow of that final digit does not enter the first digit of the following number.
- R6: `end_num` has no effect in clocks where `ph8` is low.
- R7: After a synchronous reset (`rst_n` low at a clock edge), `sum_bit` and `digit_carry` are 0 during reset and throughout the first digit period after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Synchronous reset, active low |
| a_bit | input | 1 | Serial operand A, LSB first |
| b_bit | input | 1 | Serial operand B, LSB first |
| sub | input | 1 | 1 selects B minus A, 0 selects B plus A |
| ph1 | input | 1 | Bit-phase strobe, weight 1 |
| ph2 | input | 1 | Bit-phase strobe, weight 2 |
| ph4 | input | 1 | Bit-phase strobe, weight 4 |
| ph8 | input | 1 | Bit-phase strobe, weight 8 (digit end) |
| end_num | input | 1 | Last-digit marker, sampled only with ph8 |
| sum_bit | output | 1 | Corrected serial result, one digit late |
| digit_carry | output | 1 | Decimal carry or borrow of the digit now on sum_bit |

## Verification
Several properties are checked on every clock:
- The phase strobes stay one-hot.
- `digit_carry` changes only after a weight-8 phase.
- A raw digit above nine always raises the decimal carry.
- The delay line returns each raw bit exactly four clocks later.
- The weight-1 output bit passes through the correction uncorrected.
- The operand adder starts with no carry after an end-of-number strobe.

Whether the corrected digits and flags match decimal arithmetic can only be shown by the bench scenarios. These cover:
- an exhaustive sweep of single-digit pairs in both modes;
- a sweep of three-digit operands;
- wrap cases such as 999 + 1 and 0 - 1, each followed by a fresh number;
- spurious end-of-number pulses on the early phases.

// File: rtl/bcd_ser_pkg.sv
// Package: shared constants for the serial BCD adder-subtractor.
// Assumes one digit is four bits wide and is streamed LSB first.
package bcd_ser_pkg;
    localparam int DIGIT_W = 4;
    localparam int MAX_DEC = 9;
    localparam int CORR_W1 = 1;  // index of lower set bit of the +/-6 pattern
    localparam int CORR_W2 = 2;  // index of upper set bit of the +/-6 pattern

    // One-hot bit-phase strobes of a digit
    typedef struct packed {
        logic p8;
        logic p4;
        logic p2;
        logic p1;
    } phase_t;
endpackage

// File: rtl/bcd_op_adder.sv
// Module: bcd_op_adder
// Operand serial adder-subtractor with its carry/borrow latch.
// Forms b+a or b-a bit by bit. At the weight-8 phase it combines the
// earlier raw bits (prev_bits) with the current bit into a digit and
// turns the binary carry into a decimal carry. It clears the latch when
// end_num accompanies ph8.
// Assumes prev_bits holds raw bits of weights 4,2,1 (MSB first) at ph8.
module bcd_op_adder #(
    parameter int DIGIT_W = bcd_ser_pkg::DIGIT_W,
    parameter int MAX_DEC = bcd_ser_pkg::MAX_DEC
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               a_bit,
    input  logic               b_bit,
    input  logic               sub,
    input  logic               ph8,
    input  logic               end_num,
    input  logic [DIGIT_W-2:0] prev_bits,
    output logic               raw_bit,
    output logic [DIGIT_W-1:0] raw_digit,
    output logic               dec_carry
);
    logic cy_q;
    logic bin_next;
    logic over_max;

    // Raw sum/difference bit and the binary carry or borrow it produces
    always_comb begin
        raw_bit = b_bit ^ a_bit ^ cy_q;
        if (sub)
            bin_next = (~b_bit & a_bit) | (~(b_bit ^ a_bit) & cy_q);
        else
            bin_next = (b_bit & a_bit) | ((b_bit ^ a_bit) & cy_q);
    end

    // Digit assembly and decimal carry decision for the weight-8 phase
    always_comb begin
        raw_digit = {raw_bit, prev_bits};
        over_max  = (raw_digit > DIGIT_W'(MAX_DEC));
        dec_carry = bin_next | over_max;
    end

    // Carry latch: binary carry within a digit, decimal carry across digits
    always_ff @(posedge clk) begin
        if (!rst_n)
            cy_q <= 1'b0;
        else if (ph8)
            cy_q <= end_num ? 1'b0 : dec_carry;
        else
            cy_q <= bin_next;
    end

    // R5: the first bit after an end-of-number strobe adds with no carry-in
    assert_end_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ph8 && end_num) |=> (raw_bit == (a_bit ^ b_bit)));
endmodule

// File: rtl/bcd_digit_delay.sv
// Module: bcd_digit_delay
// Shift register one digit long. Raw bits enter at the top and leave at
// the bottom exactly DIGIT_W clocks later. The newest DIGIT_W-1 bits are
// exposed so the digit can be assembled at the weight-8 phase.
// Assumes DIGIT_W is 4 (the delay check below uses a fixed depth).
module bcd_digit_delay #(
    parameter int DIGIT_W = bcd_ser_pkg::DIGIT_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_bit,
    output logic               out_bit,
    output logic [DIGIT_W-2:0] recent
);
    localparam int CNT_W = $clog2(DIGIT_W + 1);

    logic [DIGIT_W-1:0] sr_q;
    logic [CNT_W-1:0]   fill_q;

    // Shift one raw bit in per clock
    always_ff @(posedge clk) begin
        if (!rst_n)
            sr_q <= '0;
        else
            sr_q <= {in_bit, sr_q[DIGIT_W-1:1]};
    end

    // Output taps: oldest bit leaves, newer bits feed digit assembly
    always_comb begin
        out_bit = sr_q[0];
        recent  = sr_q[DIGIT_W-1:1];
    end

    // Clocks since reset, saturating at the delay depth (checker only)
    always_ff @(posedge clk) begin
        if (!rst_n)
            fill_q <= '0;
        else if (fill_q != CNT_W'(DIGIT_W))
            fill_q <= fill_q + 1'b1;
    end

    // R3: each bit leaves exactly one digit period after it entered
    assert_digit_delay_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_q == CNT_W'(DIGIT_W)) |-> (out_bit == $past(in_bit, 4)));
endmodule

// File: rtl/bcd_correct_adder.sv
// Module: bcd_correct_adder
// Reduced serial adder that adds or subtracts 0110 to the delayed digit.
// The addend is nonzero only at the weight-2 and weight-4 phases. The
// carry into the weight-1 bit is forced to zero by masking the carry
// latch at ph1.
// Assumes corr_en and corr_sub stay constant across the digit.
module bcd_correct_adder (
    input  logic clk,
    input  logic rst_n,
    input  logic d_bit,
    input  logic ph1,
    input  logic ph2,
    input  logic ph4,
    input  logic corr_en,
    input  logic corr_sub,
    output logic s_bit
);
    logic cc_q;
    logic k_bit;
    logic cin;
    logic c_next;

    // Correction addend bit and carry-in, zero carry at digit start
    always_comb begin
        k_bit = corr_en & (ph2 | ph4);
        cin   = ph1 ? 1'b0 : cc_q;
        s_bit = d_bit ^ k_bit ^ cin;
        if (corr_sub)
            c_next = (~d_bit & k_bit) | (~(d_bit ^ k_bit) & cin);
        else
            c_next = (d_bit & k_bit) | ((d_bit | k_bit) & cin);
    end

    // Correction carry/borrow latch between bits of a digit
    always_ff @(posedge clk) begin
        if (!rst_n)
            cc_q <= 1'b0;
        else
            cc_q <= c_next;
    end

    // R1: the weight-1 bit passes through the correction untouched
    assert_corr_bit1_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ph1 |-> (s_bit == d_bit));
endmodule

// File: rtl/bcd_serial_addsub.sv
// Module: bcd_serial_addsub (top)
// Serial BCD adder-subtractor: operand adder -> one-digit delay ->
// decimal correction. The decimal carry decided at ph8 is held for the
// following digit period. It selects the correction and drives
// digit_carry.
// Assumes exactly one phase strobe per clock and sub constant per number.
module bcd_serial_addsub (
    input  logic clk,
    input  logic rst_n,
    input  logic a_bit,
    input  logic b_bit,
    input  logic sub,
    input  logic ph1,
    input  logic ph2,
    input  logic ph4,
    input  logic ph8,
    input  logic end_num,
    output logic sum_bit,
    output logic digit_carry
);
    import bcd_ser_pkg::*;

    bcd_ser_pkg::phase_t ph;
    logic               raw_bit;
    logic [DIGIT_W-1:0] raw_digit;
    logic               dec_carry;
    logic               delayed_bit;
    logic [DIGIT_W-2:0] recent_bits;
    logic               dc_q;
    logic               csub_q;

    // Collect the strobes into one phase vector
    always_comb begin
        ph = '{p8: ph8, p4: ph4, p2: ph2, p1: ph1};
    end

    bcd_op_adder #(
        .DIGIT_W (DIGIT_W),
        .MAX_DEC (MAX_DEC)
    ) u_op (
        .clk       (clk),
        .rst_n     (rst_n),
        .a_bit     (a_bit),
        .b_bit     (b_bit),
        .sub       (sub),
        .ph8       (ph.p8),
        .end_num   (end_num),
        .prev_bits (recent_bits),
        .raw_bit   (raw_bit),
        .raw_digit (raw_digit),
        .dec_carry (dec_carry)
    );

    bcd_digit_delay #(
        .DIGIT_W (DIGIT_W)
    ) u_dly (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_bit  (raw_bit),
        .out_bit (delayed_bit),
        .recent  (recent_bits)
    );

    // Hold the digit's decimal carry and mode for its output period
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dc_q   <= 1'b0;
            csub_q <= 1'b0;
        end else if (ph.p8) begin
            dc_q   <= dec_carry;
            csub_q <= sub;
        end
    end

    bcd_correct_adder u_cor (
        .clk      (clk),
        .rst_n    (rst_n),
        .d_bit    (delayed_bit),
        .ph1      (ph.p1),
        .ph2      (ph.p2),
        .ph4      (ph.p4),
        .corr_en  (dc_q),
        .corr_sub (csub_q),
        .s_bit    (sum_bit)
    );

    // Drive the carry flag output from the held decision
    always_comb begin
        digit_carry = dc_q;
    end

    // R3: phase strobes are one-hot or idle
    assert_phase_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ph));

    // R4: the carry flag only changes after a digit end
    assert_carry_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !ph8 |=> $stable(digit_carry));

    // R4: a raw digit above nine always yields a decimal carry
    assert_carry_gt9_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ph8 && (raw_digit > DIGIT_W'(MAX_DEC))) |=> digit_carry);
endmodule

// File: tb/bcd_serial_addsub_bench.sv
// Bench: exhaustive single-digit sweep plus multi-digit sweeps with the
// expected digits and carries computed arithmetically.
module bcd_serial_addsub_bench;
    logic clk = 1'b0;
    logic rst_n, a_bit, b_bit, sub, ph1, ph2, ph4, ph8, end_num;
    logic sum_bit, digit_carry;

    int checks = 0;
    int errors = 0;
    int pend_d, pend_c;
    string pend_tag;

    always #5 clk = ~clk;

    bcd_serial_addsub u_bcd_serial_addsub (
        .clk(clk), .rst_n(rst_n), .a_bit(a_bit), .b_bit(b_bit), .sub(sub),
        .ph1(ph1), .ph2(ph2), .ph4(ph4), .ph8(ph8), .end_num(end_num),
        .sum_bit(sum_bit), .digit_carry(digit_carry)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Feed one operand digit over four clocks. Compare the output with the
    // digit fed one period earlier, then queue this digit's expectation.
    task automatic feed_digit(input int ad, input int bd, input bit s,
                              input bit endn, input bit noise,
                              input int nd, input int nc, input string ntag);
        int got = 0;
        int gc = 0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            a_bit = ad[k];
            b_bit = bd[k];
            sub = s;
            ph1 = (k == 0); ph2 = (k == 1); ph4 = (k == 2); ph8 = (k == 3);
            end_num = (k == 3) ? endn : noise;
            #1;
            got = got | (int'(sum_bit) << k);
            if (k == 0) gc = int'(digit_carry);
        end
        check({pend_tag, " sum digit"}, got, pend_d);
        check({pend_tag, " R4 digit_carry"}, gc, pend_c);
        pend_d = nd;
        pend_c = nc;
        pend_tag = ntag;
    endtask

    // Feed a whole n-digit number and queue decimal expectations per digit
    task automatic run_num(input int a, input int b, input bit s,
                           input int nd, input bit noise);
        int w = 1;
        for (int i = 0; i < nd; i++) begin
            int p = w * 10;
            int v, c, dig;
            string tag;
            if (s) begin
                v = (b % p) - (a % p);
                c = (v < 0) ? 1 : 0;
                if (v < 0) v = v + p;
            end else begin
                v = (a % p) + (b % p);
                c = (v >= p) ? 1 : 0;
            end
            dig = (v / w) % 10;
            tag = s ? "R2 R3" : "R1 R3";
            if (i == 0) tag = {tag, " R5"};
            if (noise) tag = {tag, " R6"};
            feed_digit((a / w) % 10, (b / w) % 10, s, (i == nd - 1), noise,
                       dig, c, tag);
            w = p;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; a_bit = 0; b_bit = 0; sub = 0;
        ph1 = 0; ph2 = 0; ph4 = 0; ph8 = 0; end_num = 0;
        repeat (3) @(negedge clk);
        #1;
        check("R7 reset sum_bit", int'(sum_bit), 0);
        check("R7 reset digit_carry", int'(digit_carry), 0);
        @(negedge clk);
        rst_n = 1'b1;
        pend_d = 0; pend_c = 0; pend_tag = "R7 first digit after reset";

        // Exhaustive single-digit sweep; end_num on every digit
        for (int s = 0; s < 2; s++)
            for (int a = 0; a < 10; a++)
                for (int b = 0; b < 10; b++)
                    run_num(a, b, s[0], 1, 1'b0);

        // Wrap cases each followed by a fresh number (R5)
        run_num(1, 999, 1'b0, 3, 1'b0);
        run_num(0, 0, 1'b0, 3, 1'b0);
        run_num(1, 0, 1'b1, 3, 1'b0);
        run_num(0, 0, 1'b1, 3, 1'b0);
        run_num(999, 999, 1'b0, 3, 1'b0);
        run_num(500, 500, 1'b1, 3, 1'b0);
        run_num(999, 0, 1'b1, 3, 1'b0);
        run_num(0, 0, 1'b0, 3, 1'b0);

        // Three-digit sweep, mixed modes, some with spurious end_num (R6)
        for (int i = 0; i < 160; i++)
            run_num((i * 379 + 17) % 1000, (i * 613 + 5) % 1000,
                    i[0], 3, (i % 3) == 0);

        feed_digit(0, 0, 1'b0, 1'b1, 1'b0, 0, 0, "flush");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule